// File: doc/BRIEF.md
# Second-Order Tracking Loop with NCO Frequency Control

This block closes a second-order tracking loop around a numerically controlled oscillator. It is the kind of loop used to recover the carrier or the symbol timing in a QPSK receiver. On each valid symbol it takes one signed phase-error sample and forms two terms from it.

The proportional term is the error shifted right arithmetically by a programmable alpha code. The integral term adds the error, shifted right by a beta code, into a saturating integrator. The NCO increment is the sum of a 22-bit nominal frequency word, the integrator and the proportional term. A phase accumulator advances by that increment once per symbol.

The nominal frequency word is written one byte at a time through a small register port. It only takes effect when its top byte is written. A lock detector compares the magnitude of the gain-scaled error against a programmable threshold and drives an active-low lock flag.

Top module: `loop_nco_ctrl`

## Requirements
- R1: After reset the active nominal word is 0x0C11D3, the integrator and the phase accumulator are zero, and `lock_n` is 1 (not locked).
- R2: The proportional term is the error, sign-extended to 22 bits and arithmetically shifted right by `alpha_sh`. After each valid symbol, `nco_inc` equals (nominal + integrator + proportional term) modulo 2^22, using that symbol's terms.
- R3: On each valid symbol the integrator adds the error arithmetically shifted right by `beta_sh`. It saturates at +2097151 and at -2097152 instead of wrapping.
- R4: On each valid symbol the phase accumulator adds the `nco_inc` value present before that symbol, modulo 2^22.
- R5: While `sym_valid` is 0, the integrator, the phase, `nco_inc` and `lock_n` hold their values whatever the error input does.
- R6: Byte writes to address 0 (bits 7:0) and address 1 (bits 15:8) are only staged. A write to address 2 commits bits 21:16 from `cfg_wdata[5:0]` together with the staged bytes. Writes to address 3 have no effect.
- R7: While unlocked, `lock_n` falls to 0 on the 16th consecutive valid symbol whose absolute proportional term is strictly below `lock_thr`. Any other symbol restarts the count.
- R8: While locked, `lock_n` rises to 1 on the 16th consecutive valid symbol whose absolute proportional term is strictly above `lock_thr`. A symbol at or below the threshold restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | One-cycle strobe marking a valid error sample |
| phase_err | input | ERR_W | Signed phase-error sample |
| alpha_sh | input | 4 | Proportional right-shift code |
| beta_sh | input | 4 | Integral right-shift code |
| lock_thr | input | ERR_W | Unsigned lock threshold |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Byte address of the nominal word |
| cfg_wdata | input | 8 | Register write data |
| nom_freq | output | 22 | Active nominal frequency word |
| integ_out | output | 22 | Integrator value (signed) |
| nco_inc | output | 22 | NCO phase increment |
| nco_phase | output | 22 | Phase accumulator |
| lock_n | output | 1 | Lock flag, 0 when locked |

## Verification
A wrong integrator value shows up in `nco_inc` right after the next valid symbol. It then drifts the phase accumulator on every symbol after that, so a single bad step never disappears from `nco_phase`. A missed saturation shows as a sign flip of `integ_out` at the limit. A miscounted lock run moves the edge of `lock_n` by at least one symbol from the 16th qualifying sample. A staged byte that leaks into the active word changes `nom_freq` and `nco_inc` before the top byte is written.

// File: rtl/loop_nco_ctrl.sv
module loop_nco_ctrl #(
  parameter int ERR_W    = 12,
  parameter int LOCK_LEN = 16,
  parameter logic [21:0] NOM_RST = 22'h0C11D3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic [ERR_W-1:0] phase_err,
  input  logic [3:0]       alpha_sh,
  input  logic [3:0]       beta_sh,
  input  logic [ERR_W-1:0] lock_thr,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [21:0]      nom_freq,
  output logic [21:0]      integ_out,
  output logic [21:0]      nco_inc,
  output logic [21:0]      nco_phase,
  output logic             lock_n
);
  localparam int FW    = 22;
  localparam int CNT_W = $clog2(LOCK_LEN + 1);
  localparam logic signed [FW:0] IMAX = (23'sd1 <<< (FW - 1)) - 23'sd1;
  localparam logic signed [FW:0] IMIN = -(23'sd1 <<< (FW - 1));

  logic [7:0] stg0, stg1;
  logic [FW-1:0] nom_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg0  <= NOM_RST[7:0];
      stg1  <= NOM_RST[15:8];
      nom_q <= NOM_RST;
    end else if (cfg_wr) begin
      case (cfg_addr)
        2'd0: stg0 <= cfg_wdata;
        2'd1: stg1 <= cfg_wdata;
        2'd2: nom_q <= {cfg_wdata[FW-17:0], stg1, stg0};
        default: ;
      endcase
    end
  end

  logic signed [FW-1:0] err_x, p_term, i_term, integ_q, prop_q;
  logic signed [FW:0] i_sum;
  assign err_x  = FW'($signed(phase_err));
  assign p_term = err_x >>> alpha_sh;
  assign i_term = err_x >>> beta_sh;
  assign i_sum  = {integ_q[FW-1], integ_q} + {i_term[FW-1], i_term};

  logic [FW-1:0] phase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      prop_q  <= '0;
      phase_q <= '0;
    end else if (sym_valid) begin
      prop_q  <= p_term;
      phase_q <= phase_q + nco_inc;
      if (i_sum > IMAX)      integ_q <= IMAX[FW-1:0];
      else if (i_sum < IMIN) integ_q <= IMIN[FW-1:0];
      else                   integ_q <= i_sum[FW-1:0];
    end
  end

  assign nom_freq  = nom_q;
  assign integ_out = integ_q;
  assign nco_inc   = nom_q + integ_q + prop_q;
  assign nco_phase = phase_q;

  logic [FW-1:0] p_abs, thr_x;
  logic below, above, hit;
  logic [CNT_W-1:0] run_q;
  assign p_abs = p_term[FW-1] ? FW'(-p_term) : FW'(p_term);
  assign thr_x = FW'(lock_thr);
  assign below = p_abs < thr_x;
  assign above = p_abs > thr_x;
  assign hit   = lock_n ? below : above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_n <= 1'b1;
    end else if (sym_valid) begin
      if (!hit) run_q <= '0;
      else if (run_q == CNT_W'(LOCK_LEN - 1)) begin
        run_q  <= '0;
        lock_n <= ~lock_n;
      end else run_q <= run_q + 1'b1;
    end
  end

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && integ_q == IMAX[FW-1:0] && !phase_err[ERR_W-1] |=> integ_q == IMAX[FW-1:0]);
  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && integ_q == IMIN[FW-1:0] && phase_err[ERR_W-1] |=> integ_q == IMIN[FW-1:0]);
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> nco_phase == FW'($past(nco_phase) + $past(nco_inc)));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(nco_phase) && $stable(integ_out) && $stable(lock_n));
  p_nom_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == 2'd2) |=> $stable(nom_freq));
  p_lock_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && lock_n && !below |=> lock_n);
  p_unlock_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !lock_n && !above |=> !lock_n);
endmodule

// File: tb/loop_nco_ctrl_tb.sv
module loop_nco_ctrl_tb;
  localparam int CLK_P = 10;
  localparam longint M22 = 64'h3FFFFF;

  logic clk = 0, rst_n = 0, sym_valid = 0, cfg_wr = 0;
  logic [11:0] phase_err = '0, lock_thr = '0;
  logic [3:0] alpha_sh = '0, beta_sh = '0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [21:0] nom_freq, integ_out, nco_inc, nco_phase;
  logic lock_n;

  loop_nco_ctrl u_dut (.clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .phase_err(phase_err),
    .alpha_sh(alpha_sh), .beta_sh(beta_sh), .lock_thr(lock_thr), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .nom_freq(nom_freq), .integ_out(integ_out),
    .nco_inc(nco_inc), .nco_phase(nco_phase), .lock_n(lock_n));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint nom_m = 64'h0C11D3, integ_m = 0, prop_m = 0, phase_m = 0, inc_m = 64'h0C11D3;
  logic lock_m = 1;
  int run_m = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int e, input int a, input int b, input int thr);
    longint p, t, s;
    phase_err = 12'(e); alpha_sh = 4'(a); beta_sh = 4'(b); lock_thr = 12'(thr);
    sym_valid = 1;
    @(negedge clk);
    sym_valid = 0;
    phase_m = (phase_m + inc_m) & M22;
    p = longint'(e) >>> a;
    t = longint'(e) >>> b;
    prop_m = p;
    s = integ_m + t;
    integ_m = (s > 2097151) ? 2097151 : (s < -2097152) ? -2097152 : s;
    inc_m = (nom_m + integ_m + prop_m) & M22;
    if (p < 0) p = -p;
    if (lock_m ? (p < thr) : (p > thr)) begin
      run_m++;
      if (run_m == 16) begin lock_m = ~lock_m; run_m = 0; end
    end else run_m = 0;
    chk("R2 nco_inc", longint'(nco_inc), inc_m);
    chk("R3 integrator", longint'($signed(integ_out)), integ_m);
    chk("R4 phase", longint'(nco_phase), phase_m);
    chk("R7/R8 lock_n", longint'(lock_n), longint'(lock_m));
  endtask

  task automatic wr(input int ad, input int d);
    cfg_addr = 2'(ad); cfg_wdata = 8'(d); cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    if (ad == 2) begin
      nom_m = ((longint'(d) & 63) << 16) | (nom_m_stage & 16'hFFFF);
      inc_m = (nom_m + integ_m + prop_m) & M22;
    end else if (ad == 0) nom_m_stage = (nom_m_stage & 16'hFF00) | longint'(d);
    else if (ad == 1) nom_m_stage = (nom_m_stage & 16'h00FF) | (longint'(d) << 8);
  endtask
  longint nom_m_stage = 64'h11D3;

  initial begin
    #(CLK_P * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 nom", longint'(nom_freq), 64'h0C11D3);
    chk("R1 integ", longint'(integ_out), 0);
    chk("R1 phase", longint'(nco_phase), 0);
    chk("R1 lock_n", longint'(lock_n), 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 inc", longint'(nco_inc), 64'h0C11D3);

    // R2 R3 R4 sweep over shift codes and error values
    for (int a = 0; a < 16; a++)
      for (int bi = 0; bi < 4; bi++)
        for (int e = -2048; e < 2048; e += 173)
          step(e, a, bi * 5, 0);

    // R3 saturation both ways
    for (int i = 0; i < 1100; i++) step(2047, 0, 0, 0);
    chk("R3 max clamp", longint'($signed(integ_out)), 2097151);
    for (int i = 0; i < 2100; i++) step(-2048, 0, 0, 0);
    chk("R3 min clamp", longint'($signed(integ_out)), -2097152);
    step(1000, 3, 2, 0);

    // R5 idle holds
    begin
      logic [21:0] ph, ig, ic;
      ph = nco_phase; ig = integ_out; ic = nco_inc;
      for (int i = 0; i < 6; i++) begin phase_err = 12'(i * 300 - 900); @(negedge clk); end
      chk("R5 phase hold", longint'(nco_phase), longint'(ph));
      chk("R5 integ hold", longint'(integ_out), longint'(ig));
      chk("R5 inc hold", longint'(nco_inc), longint'(ic));
    end

    // R6 staged writes
    wr(0, 8'h55); chk("R6 byte0 staged", longint'(nom_freq), 64'h0C11D3);
    wr(1, 8'hAA); chk("R6 byte1 staged", longint'(nom_freq), 64'h0C11D3);
    wr(3, 8'hFF); chk("R6 addr3 ignored", longint'(nom_freq), 64'h0C11D3);
    chk("R6 inc unchanged", longint'(nco_inc), inc_m);
    wr(2, 8'hFF); chk("R6 commit", longint'(nom_freq), 64'h3FAA55);
    chk("R6 inc follows", longint'(nco_inc), inc_m);
    wr(2, 8'h01); chk("R6 recommit", longint'(nom_freq), 64'h01AA55);
    step(-7, 1, 4, 0);

    // R7 lock acquisition with restarts, threshold 100
    for (int i = 0; i < 8; i++) step(10, 0, 15, 100);
    step(100, 0, 15, 100);
    for (int i = 0; i < 15; i++) step(-50, 0, 15, 100);
    chk("R7 not yet locked", longint'(lock_n), 1);
    step(99, 0, 15, 100);
    chk("R7 locked on 16th", longint'(lock_n), 0);

    // R8 loss of lock, equal value restarts the run
    for (int i = 0; i < 10; i++) step(-200, 0, 15, 100);
    step(100, 0, 15, 100);
    for (int i = 0; i < 15; i++) step(400, 1, 15, 100);
    chk("R8 still locked", longint'(lock_n), 0);
    step(202, 0, 15, 100);
    chk("R8 unlocked on 16th", longint'(lock_n), 1);

    // R7 with alpha scaling the compared term
    for (int i = 0; i < 16; i++) step(800, 4, 15, 51);
    chk("R7 alpha-scaled lock", longint'(lock_n), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule